// File: doc/BRIEF.md
# Pin-to-Resource Routing Matrix

This block lets each of a group of general-purpose digital input pins be routed to one of a few internal consumers: the clock/gate inputs of two timers and two interrupt request lines, a high-priority one and a low-priority one. Each interrupt line can be triggered by a rising or a falling edge. Every pin has its own 3-bit selector. The selector either picks one consumer and one edge polarity, or it leaves the pin disconnected. When several pins select the same consumer, the consumer sees the OR of their contributions.

Pin levels first pass through a two-flop synchroniser. A small tracker state machine per pin then turns the synchronised level into single-cycle rising and falling edge strobes. After reset, each tracker waits in three settle states (`TRK_RESET` → `TRK_FILL` → `TRK_ARM`). It then takes the `TRK_LOW` or `TRK_HIGH` state, depending on the level it sees at that point, so a level present at reset is never reported as an edge. Two transitions report edges:

- `TRK_LOW` → `TRK_HIGH` issues the rise strobe.
- `TRK_HIGH` → `TRK_LOW` issues the fall strobe.

The block also holds a direction bit per pin and drives that pin's output enable. The lowest pin is input-only.

Configuration is written one pin at a time. A write sets both the selector and the direction bit of the indexed pin. Timer inputs follow the synchronised level combinationally. Interrupt outputs are registered one-cycle pulses.

Top module: `pin_route_matrix`

## Requirements
- R1: While reset is asserted and right after it, all selectors and direction bits are 0, and every output (both timer inputs, both interrupt outputs, all output enables) is 0.
- R2: A pin whose selector is 000 (disconnected) or 001 (reserved, also disconnected) has no effect on any timer or interrupt output, whatever its level does.
- R3: Selector 010 routes the pin level to timer 0, and 011 routes it to timer 1. A timer input equals the OR of the levels of its routed pins, 2 clock edges after the pin changes.
- R4: Selector 100 (high priority) and 101 (low priority) make a rising pin edge give a one-cycle pulse on that interrupt output, 3 clock edges after the pin change. Falling edges on such a pin are ignored.
- R5: Selector 110 (high priority) and 111 (low priority) make a falling pin edge give a one-cycle pulse on that interrupt output, 3 clock edges after the pin change. Rising edges on such a pin are ignored.
- R6: All contributions to one interrupt line are ORed. This covers several pins, and rising-variant and falling-variant pins together. Edges arriving in the same cycle give a single one-cycle pulse.
- R7: A pin's output enable is 1 only when its direction bit is 1 and its selector is 000 or 001. The direction bit is ignored while the pin is routed to a resource. Pin 0 is input-only, and its output enable is always 0.
- R8: Pin levels present when reset is released produce no interrupt pulse, even when the pin is routed to an edge interrupt right away.
- R9: A configuration write whose pin index is NUM_PINS or larger changes no selector and no direction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Pin index of the write |
| cfg_sel | input | 3 | Selector code written |
| cfg_dir | input | 1 | Direction bit written (1 = output) |
| tmr0_in | output | 1 | Timer 0 clock/gate input |
| tmr1_in | output | 1 | Timer 1 clock/gate input |
| irq_hi | output | 1 | High-priority interrupt pulse |
| irq_lo | output | 1 | Low-priority interrupt pulse |
| pin_oe | output | NUM_PINS | Per-pin output enable |

## Verification
Single pins are toggled in both directions on every code, which separates the rising and falling variants and shows that the opposite polarity is ignored. Two pins that share a timer change levels in the same cycle, which tells an OR from a pass-through of a single pin. Simultaneous rising edges on two pins, and a rising edge coinciding with a falling edge on the same line, tell a single merged pulse from a doubled or lost one. Pins held high across reset release, an out-of-range write index aliasing onto a routed pin, and direction writes on routed and input-only pins cover the corner cases.

// File: rtl/pinroute_pkg.sv
package pinroute_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        RES_NONE    = 3'b000,
        RES_RSVD    = 3'b001,
        RES_TMR0    = 3'b010,
        RES_TMR1    = 3'b011,
        RES_HI_RISE = 3'b100,
        RES_LO_RISE = 3'b101,
        RES_HI_FALL = 3'b110,
        RES_LO_FALL = 3'b111
    } res_sel_e;

    typedef enum logic [2:0] {
        TRK_RESET = 3'd0,
        TRK_FILL  = 3'd1,
        TRK_ARM   = 3'd2,
        TRK_LOW   = 3'd3,
        TRK_HIGH  = 3'd4
    } trk_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;

endmodule

// File: rtl/pin_edge_fsm.sv
module pin_edge_fsm
    import pinroute_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    trk_state_e state_q;
    trk_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: three settle states, then level tracking
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_RESET: state_d = TRK_FILL;
            TRK_FILL:  state_d = TRK_ARM;
            TRK_ARM:   state_d = lvl ? TRK_HIGH : TRK_LOW;
            TRK_LOW:   state_d = lvl ? TRK_HIGH : TRK_LOW;
            TRK_HIGH:  state_d = lvl ? TRK_HIGH : TRK_LOW;
            default:   state_d = TRK_RESET;
        endcase
    end

    // outputs: strobes on the LOW->HIGH and HIGH->LOW transitions only
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            TRK_LOW:  rise = lvl;
            TRK_HIGH: fall = !lvl;
            default: begin
                rise = 1'b0;
                fall = 1'b0;
            end
        endcase
    end

    // R4: a rising strobe lasts one cycle
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R5: a falling strobe lasts one cycle
    a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

    // R8: the first tracked state reflects the level, with no strobe on entry
    a_r8_arm_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_ARM) |-> (!rise && !fall));

endmodule

// File: rtl/route_cfg_regs.sv
module route_cfg_regs
    import pinroute_pkg::*;
#(
    parameter int NUM_PINS = 11,
    parameter int IDX_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_idx,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic                           cfg_dir,
    output logic [NUM_PINS-1:0][SEL_W-1:0] sel_q,
    output logic [NUM_PINS-1:0]            dir_q
);

    logic idx_ok;
    assign idx_ok = (int'(cfg_idx) < NUM_PINS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            dir_q <= '0;
        end else if (cfg_we && idx_ok) begin
            sel_q[cfg_idx] <= cfg_sel;
            dir_q[cfg_idx] <= cfg_dir;
        end
    end

    // R9: out-of-range writes leave every field unchanged
    a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_idx) >= NUM_PINS)) |=> ($stable(sel_q) && $stable(dir_q)));

endmodule

// File: rtl/route_merge.sv
module route_merge
    import pinroute_pkg::*;
#(
    parameter int                  NUM_PINS     = 11,
    parameter logic [NUM_PINS-1:0] IN_ONLY_MASK = 1
) (
    input  logic [NUM_PINS-1:0][SEL_W-1:0] sel,
    input  logic [NUM_PINS-1:0]            dir,
    input  logic [NUM_PINS-1:0]            lvl,
    input  logic [NUM_PINS-1:0]            rise,
    input  logic [NUM_PINS-1:0]            fall,
    output logic                           tmr0,
    output logic                           tmr1,
    output logic                           hi_d,
    output logic                           lo_d,
    output logic [NUM_PINS-1:0]            oe
);

    always_comb begin
        tmr0 = 1'b0;
        tmr1 = 1'b0;
        hi_d = 1'b0;
        lo_d = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            case (res_sel_e'(sel[i]))
                RES_TMR0:    tmr0 = tmr0 | lvl[i];
                RES_TMR1:    tmr1 = tmr1 | lvl[i];
                RES_HI_RISE: hi_d = hi_d | rise[i];
                RES_LO_RISE: lo_d = lo_d | rise[i];
                RES_HI_FALL: hi_d = hi_d | fall[i];
                RES_LO_FALL: lo_d = lo_d | fall[i];
                default:     ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_oe
        if (IN_ONLY_MASK[g]) begin : g_in_only
            assign oe[g] = 1'b0;
        end else begin : g_bidir
            assign oe[g] = dir[g] & (sel[g][SEL_W-1:1] == '0);
        end
    end

endmodule

// File: rtl/pin_route_matrix.sv
module pin_route_matrix
    import pinroute_pkg::*;
#(
    parameter int                  NUM_PINS     = 11,
    parameter logic [NUM_PINS-1:0] IN_ONLY_MASK = 1,
    parameter int                  IDX_W        = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [2:0]          cfg_sel,
    input  logic                cfg_dir,
    output logic                tmr0_in,
    output logic                tmr1_in,
    output logic                irq_hi,
    output logic                irq_lo,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam int BOOT_W = 2;

    logic [NUM_PINS-1:0]            lvl_sync;
    logic [NUM_PINS-1:0]            rise_s;
    logic [NUM_PINS-1:0]            fall_s;
    logic [NUM_PINS-1:0][SEL_W-1:0] sel_q;
    logic [NUM_PINS-1:0]            dir_q;
    logic                           hi_d;
    logic                           lo_d;
    logic                           irq_hi_q;
    logic                           irq_lo_q;
    logic [BOOT_W-1:0]              boot_cnt;

    pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (lvl_sync)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_trk
        pin_edge_fsm u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (lvl_sync[g]),
            .rise  (rise_s[g]),
            .fall  (fall_s[g])
        );
    end

    route_cfg_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_idx (cfg_idx),
        .cfg_sel (cfg_sel),
        .cfg_dir (cfg_dir),
        .sel_q   (sel_q),
        .dir_q   (dir_q)
    );

    route_merge #(.NUM_PINS(NUM_PINS), .IN_ONLY_MASK(IN_ONLY_MASK)) u_merge (
        .sel  (sel_q),
        .dir  (dir_q),
        .lvl  (lvl_sync),
        .rise (rise_s),
        .fall (fall_s),
        .tmr0 (tmr0_in),
        .tmr1 (tmr1_in),
        .hi_d (hi_d),
        .lo_d (lo_d),
        .oe   (pin_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_hi_q <= 1'b0;
            irq_lo_q <= 1'b0;
            boot_cnt <= '0;
        end else begin
            irq_hi_q <= hi_d;
            irq_lo_q <= lo_d;
            if (boot_cnt != '1) begin
                boot_cnt <= boot_cnt + 1'b1;
            end
        end
    end

    assign irq_hi = irq_hi_q;
    assign irq_lo = irq_lo_q;

    // R8: no interrupt while the trackers are still settling
    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cnt != '1) |-> (!irq_hi && !irq_lo));

    // R3: a timer input is high only if some synchronised pin level is high
    a_r3_timer_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr0_in || tmr1_in) |-> (|lvl_sync));

    // R6: an interrupt pulse needs an edge strobe one cycle earlier
    a_r6_irq_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi || irq_lo) |-> $past(|(rise_s | fall_s)));

    // R7: input-only pins never drive
    a_r7_input_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & IN_ONLY_MASK) == '0);

    // R7: an enabled output implies the direction bit was written
    a_r7_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_q) == '0);

endmodule

// File: tb/pin_route_matrix_tb.sv
module pin_route_matrix_tb_top;

    localparam int NP = 11;
    localparam int IW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [2:0]    cfg_sel = '0;
    logic          cfg_dir = 1'b0;
    logic          tmr0_in, tmr1_in, irq_hi, irq_lo;
    logic [NP-1:0] pin_oe;

    pin_route_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_dir(cfg_dir),
        .tmr0_in(tmr0_in), .tmr1_in(tmr1_in), .irq_hi(irq_hi),
        .irq_lo(irq_lo), .pin_oe(pin_oe)
    );

    always #2 clk = ~clk;

    typedef struct {
        int            cyc;
        logic [3:0]    exp4;
        logic [3:0]    m4;
        logic          chk_oe;
        logic [NP-1:0] exp_oe;
        string         tag;
    } item_t;

    item_t      sb_q[$];
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    logic [2:0] sel_m [NP];
    logic       dir_m [NP];
    logic [NP-1:0] pin_m;
    bit         done = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [3:0] model_out(logic [NP-1:0] v, logic [NP-1:0] prev);
        logic t0, t1, hi, lo;
        t0 = 0; t1 = 0; hi = 0; lo = 0;
        for (int i = 0; i < NP; i++) begin
            case (sel_m[i])
                3'b010: t0 |= v[i];
                3'b011: t1 |= v[i];
                3'b100: hi |= v[i] & ~prev[i];
                3'b101: lo |= v[i] & ~prev[i];
                3'b110: hi |= ~v[i] & prev[i];
                3'b111: lo |= ~v[i] & prev[i];
                default: ;
            endcase
        end
        return {t0, t1, hi, lo};
    endfunction

    function automatic logic [NP-1:0] model_oe();
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = (i != 0) && dir_m[i] && (sel_m[i][2:1] == 2'b00);
        return r;
    endfunction

    task automatic push(item_t it);
        int pos;
        pos = sb_q.size();
        for (int k = 0; k < sb_q.size(); k++) begin
            if (sb_q[k].cyc > it.cyc) begin
                pos = k;
                break;
            end
        end
        sb_q.insert(pos, it);
    endtask

    task automatic push4(int c, logic [3:0] e, logic [3:0] m, string tag);
        item_t it;
        it.cyc = c; it.exp4 = e; it.m4 = m; it.chk_oe = 0; it.exp_oe = '0; it.tag = tag;
        push(it);
    endtask

    // monitor: compares scoreboard items at their due cycle
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                item_t it;
                logic [3:0] act;
                it = sb_q.pop_front();
                act = {tmr0_in, tmr1_in, irq_hi, irq_lo};
                if (it.m4 != 0) begin
                    n_chk++;
                    if (((act ^ it.exp4) & it.m4) != 0 || it.cyc != cyc) begin
                        n_fail++;
                        $display("FAIL %s cyc %0d: outputs {t0,t1,hi,lo} act %b exp %b mask %b",
                                 it.tag, cyc, act, it.exp4, it.m4);
                    end
                end
                if (it.chk_oe) begin
                    n_chk++;
                    if (pin_oe !== it.exp_oe || it.cyc != cyc) begin
                        n_fail++;
                        $display("FAIL %s cyc %0d: pin_oe act %b exp %b", it.tag, cyc, pin_oe, it.exp_oe);
                    end
                end
            end
        end
    end

    task automatic write_cfg(int idx, logic [2:0] s, logic d, string tag);
        item_t it;
        cfg_we = 1; cfg_idx = IW'(idx); cfg_sel = s; cfg_dir = d;
        if (idx < NP) begin
            sel_m[idx] = s;
            dir_m[idx] = d;
        end
        it.cyc = cyc + 1; it.exp4 = '0; it.m4 = '0; it.chk_oe = 1;
        it.exp_oe = model_oe(); it.tag = tag;
        push(it);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic drive(logic [NP-1:0] v, string tag);
        logic [3:0] e;
        e = model_out(v, pin_m);
        pin_in = v;
        push4(cyc + 2, e, 4'b1100, tag);
        push4(cyc + 3, e, 4'b1111, tag);
        push4(cyc + 4, {e[3:2], 2'b00}, 4'b1111, tag);
        pin_m = v;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [NP-1:0] cur;
        for (int i = 0; i < NP; i++) begin
            sel_m[i] = 0;
            dir_m[i] = 0;
        end
        pin_m = '1;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        n_chk++;
        if ({tmr0_in, tmr1_in, irq_hi, irq_lo} !== 4'b0 || pin_oe !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: outputs %b oe %b exp 0000 / 0",
                     {tmr0_in, tmr1_in, irq_hi, irq_lo}, pin_oe);
        end
        rst_n = 1;
        // R8: pins high across reset, pin 3 routed to rising high interrupt at once
        for (int c = 1; c <= 6; c++) push4(c, 4'b0000, 4'b1111, "R8");
        write_cfg(3, 3'b100, 0, "R1");
        repeat (6) @(negedge clk);
        cur = '0;
        drive(cur, "R4 fall ignored");
        cur[3] = 1; drive(cur, "R4 rise pulse");
        write_cfg(5, 3'b111, 0, "R5");
        cur[5] = 1; drive(cur, "R5 rise ignored");
        cur[5] = 0; drive(cur, "R5 fall pulse");
        write_cfg(1, 3'b010, 0, "R3");
        write_cfg(2, 3'b010, 0, "R3");
        write_cfg(4, 3'b011, 0, "R3");
        cur[1] = 1; drive(cur, "R3 timer0");
        cur[4] = 1; drive(cur, "R3 timer1");
        cur[1] = 0; cur[2] = 1; drive(cur, "R6 timer0 OR");
        cur[2] = 0; cur[4] = 0; drive(cur, "R3 timers low");
        write_cfg(6, 3'b100, 0, "R6");
        cur[3] = 0; drive(cur, "R6 fall ignored");
        cur[3] = 1; cur[6] = 1; drive(cur, "R6 merged rises");
        write_cfg(7, 3'b110, 0, "R6");
        cur[7] = 1; drive(cur, "R6 rise on fall code");
        cur[3] = 0; cur[6] = 0; drive(cur, "R6 setup");
        cur[3] = 1; cur[7] = 0; drive(cur, "R6 rise+fall merged");
        write_cfg(8, 3'b001, 1, "R7 reserved dir");
        cur[8] = 1; cur[9] = 1; drive(cur, "R2 unrouted high");
        cur[8] = 0; cur[9] = 0; drive(cur, "R2 unrouted low");
        write_cfg(3, 3'b100, 1, "R7 routed dir");
        write_cfg(0, 3'b011, 1, "R7 input-only");
        write_cfg(10, 3'b000, 1, "R7 plain output");
        cur[0] = 1; drive(cur, "R3 pin0 timer1");
        write_cfg(13, 3'b100, 0, "R9 oob");
        cur[5] = 1; drive(cur, "R9 pin5 rise");
        cur[5] = 0; drive(cur, "R9 pin5 fall");
        repeat (10) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d items left, exp 0", sb_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run not finished, act hung exp done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule